// File: doc/BRIEF.md
# Video RAM Read-Transfer Serial Port

This block models a dual-port video memory. A small array of 4-bit words is reached through a random port with multiplexed row and column addresses, strobed by active-low row and column strobes. A 512-entry serial register can be filled from the array in one step and then streamed out one word per serial clock. Page-mode random cycles write words into the array and read them back on a tri-state data port. A transfer cycle copies an entire row into the serial register in parallel.

A cycle is a transfer when the transfer-gate input is low as the row strobe falls. The address at the row-strobe fall picks the row. The address at the following column-strobe fall is the tap, which is the first column to be streamed. The copy happens when the transfer gate returns high, even if the row strobe has already gone high. After the copy, the serial port turns to output. Data appears only after the next serial clock rise. Each later rise advances a 9-bit pointer that wraps at the top. A status flag mirrors the pointer's upper half.

All strobes and the serial clock are sampled on a system clock. Edges are detected between consecutive samples.

Top module: `vram_xfer_port`

## Requirements
- R1: With the row strobe low, a column-strobe fall with `we_ni` low writes `dq_i` to the addressed word. With `we_ni` high, the word is driven on `dq_o` with `dq_oe_o` high one clock later. `dq_oe_o` drops one clock after the column strobe or row strobe rises.
- R2: A row-strobe fall with `trg_ni` low starts a transfer cycle. `dq_oe_o` stays low for the whole transfer cycle, including its column-strobe fall.
- R3: The transfer copies all 512 columns of the latched row into the serial register. A full lap of 512 serial shifts returns that row's words in column order.
- R4: The address at the column-strobe fall of a transfer cycle is the tap. The first word shifted out after the transfer is the word at the tap column.
- R5: The serial register loads two clocks after `trg_ni` rises. After the load, the port is in output mode. `sdq_oe_o` stays low until the first `sc_i` rise with `se_ni` low. From then on, it is high whenever `se_ni` is low.
- R6: Each `sc_i` rise with `se_ni` low presents the word at the pointer on `sdq_o` one clock later and increments the pointer. The pointer wraps from 511 to 0.
- R7: While `se_ni` is high, `sdq_oe_o` is low and `sc_i` rises leave the pointer unchanged. When `se_ni` returns low, the stream resumes at the next column.
- R8: `qsf_o` equals bit 8 of the serial pointer. It takes the tap's bit 8 at the load and follows the pointer as it advances.
- R9: A late-load transfer completes the copy correctly and starts at the tap. In a late load, `trg_ni` rises after both strobes have returned high.
- R10: From reset until the first transfer, the serial port is in input mode. In input mode, `sdq_oe_o` stays low even while `sc_i` toggles with `se_ni` low.
- R11: After reset, `dq_oe_o`, `sdq_oe_o` and `qsf_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all strobes |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| trg_ni | input | 1 | Transfer gate, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 9 | Multiplexed row / column / tap address |
| dq_i | input | 4 | Random-port write data |
| dq_o | output | 4 | Random-port read data |
| dq_oe_o | output | 1 | Random-port output enable |
| sc_i | input | 1 | Serial clock |
| se_ni | input | 1 | Serial enable, active low |
| sdq_i | input | 4 | Serial input data (input mode) |
| sdq_o | output | 4 | Serial output data |
| sdq_oe_o | output | 1 | Serial port output enable |
| qsf_o | output | 1 | Serial pointer upper-half flag |

## Verification
The hardest state to reach is a pointer that crosses from column 511 to 0 while the flag and the data stream stay consistent. The bench gets there with a tap of 508 and then streams through the wrap, checking the flag before and after. A complete 512-word lap from a mid-row tap shows that every column was copied, not only those near the tap. The late-load variant is reached by raising both strobes and idling before releasing the transfer gate. Serial-enable gaps inserted mid-stream show that the pointer holds.

// File: rtl/vram_pkg.sv
package vram_pkg;
  typedef enum logic {
    SAM_IN  = 1'b0,
    SAM_OUT = 1'b1
  } sam_dir_e;
endpackage

// File: rtl/vram_edge.sv
module vram_edge #(
  parameter int unsigned    N    = 4,
  parameter logic [N-1:0]   IDLE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_o <= IDLE;
    else         prev_o <= sig_i;
  end
endmodule

// File: rtl/vram_array.sv
module vram_array #(
  parameter int unsigned ROWS   = 4,
  parameter int unsigned COLS   = 512,
  parameter int unsigned DQ_W   = 4,
  parameter int unsigned ADDR_W = $clog2(COLS)
) (
  input  logic                   clk_i,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      row_i,
  input  logic [ADDR_W-1:0]      col_i,
  input  logic [DQ_W-1:0]        din_i,
  output logic [DQ_W-1:0]        rd_data_o,
  output logic [COLS*DQ_W-1:0]   row_bus_o
);
  localparam int unsigned ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [DQ_W-1:0]  mem [ROWS][COLS];
  logic [ROW_W-1:0] row_idx;

  // rows beyond ROWS alias onto the implemented ones
  assign row_idx = ROW_W'(row_i % ADDR_W'(ROWS));

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[row_idx][col_i] <= din_i;
  end

  assign rd_data_o = mem[row_idx][col_i];

  for (genvar c = 0; c < COLS; c++) begin : g_row_bus
    assign row_bus_o[c*DQ_W +: DQ_W] = mem[row_idx][c];
  end
endmodule

// File: rtl/vram_ctrl.sv
module vram_ctrl #(
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned DQ_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              ras_fall_i,
  input  logic              ras_rise_i,
  input  logic              cas_fall_i,
  input  logic              cas_rise_i,
  input  logic              trg_ni,
  input  logic              trg_rise_i,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   rd_data_i,
  output logic [ADDR_W-1:0] row_o,
  output logic [ADDR_W-1:0] col_o,
  output logic              wr_en_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic              load_o,
  output logic [ADDR_W-1:0] tap_o
);
  logic [ADDR_W-1:0] row_q, tap_q;
  logic [DQ_W-1:0]   dq_q;
  logic              xfer_q, dq_oe_q, load_q;
  logic              cas_act, rd_hit;

  assign cas_act = cas_fall_i & ~ras_ni;
  assign wr_en_o = cas_act & ~xfer_q & ~we_ni;
  assign rd_hit  = cas_act & ~xfer_q & we_ni;
  assign col_o   = addr_i;
  assign row_o   = row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q   <= '0;
      tap_q   <= '0;
      xfer_q  <= 1'b0;
      dq_q    <= '0;
      dq_oe_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (ras_fall_i) begin
        row_q  <= addr_i;
        xfer_q <= ~trg_ni;
      end
      if (cas_act && xfer_q) tap_q <= addr_i;
      // copy fires on gate release, whether or not RAS is still low
      if (trg_rise_i && xfer_q && !ras_fall_i) begin
        load_q <= 1'b1;
        xfer_q <= 1'b0;
      end
      if (rd_hit) begin
        dq_q    <= rd_data_i;
        dq_oe_q <= 1'b1;
      end else if (cas_rise_i || ras_rise_i || ras_fall_i) begin
        dq_oe_q <= 1'b0;
      end
    end
  end

  assign dq_o    = dq_q;
  assign dq_oe_o = dq_oe_q;
  assign load_o  = load_q;
  assign tap_o   = tap_q;

  a_r2_dq_hiz_in_xfer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_q |-> !dq_oe_q);

  a_r9_late_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trg_rise_i && xfer_q && ras_ni && !ras_fall_i) |=> load_q);

  a_r1_read_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |=> dq_oe_q);
endmodule

// File: rtl/vram_sam.sv
module vram_sam
  import vram_pkg::*;
#(
  parameter int unsigned COLS = 512,
  parameter int unsigned DQ_W = 4,
  parameter int unsigned PTR_W = $clog2(COLS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [PTR_W-1:0]     tap_i,
  input  logic [COLS*DQ_W-1:0] row_bus_i,
  input  logic                 sc_rise_i,
  input  logic                 se_ni,
  input  logic [DQ_W-1:0]      sdq_i,
  output logic [DQ_W-1:0]      sdq_o,
  output logic                 sdq_oe_o,
  output logic                 qsf_o
);
  logic [DQ_W-1:0]  sam [COLS];
  logic [PTR_W-1:0] ptr_q;
  logic [DQ_W-1:0]  sdq_q;
  sam_dir_e         dir_q;
  logic             primed_q;
  logic             step;

  assign step = sc_rise_i & ~se_ni & ~load_i;

  always_ff @(posedge clk_i) begin
    if (load_i) begin
      for (int c = 0; c < COLS; c++) sam[c] <= row_bus_i[c*DQ_W +: DQ_W];
    end else if (step && dir_q == SAM_IN) begin
      sam[ptr_q] <= sdq_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      sdq_q    <= '0;
      dir_q    <= SAM_IN;
      primed_q <= 1'b0;
    end else if (load_i) begin
      ptr_q    <= tap_i;
      dir_q    <= SAM_OUT;
      primed_q <= 1'b0;
    end else if (step) begin
      ptr_q <= ptr_q + 1'b1;
      if (dir_q == SAM_OUT) begin
        sdq_q    <= sam[ptr_q];
        primed_q <= 1'b1;
      end
    end
  end

  assign sdq_o    = sdq_q;
  assign sdq_oe_o = (dir_q == SAM_OUT) & primed_q & ~se_ni;
  assign qsf_o    = ptr_q[PTR_W-1];

  a_r6_ptr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |=> ptr_q == $past(ptr_q) + 1'b1);

  a_r7_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (se_ni && !load_i) |=> ptr_q == $past(ptr_q));

  a_r5_quiet_after_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !sdq_oe_o);

  a_r8_qsf_from_tap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> qsf_o == $past(tap_i[PTR_W-1]));
endmodule

// File: rtl/vram_xfer_port.sv
module vram_xfer_port #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 512,
  parameter int unsigned DQ_W = 4,
  parameter int unsigned ADDR_W = $clog2(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              trg_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   dq_i,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  input  logic              sc_i,
  input  logic              se_ni,
  input  logic [DQ_W-1:0]   sdq_i,
  output logic [DQ_W-1:0]   sdq_o,
  output logic              sdq_oe_o,
  output logic              qsf_o
);
  logic [3:0]           prv;
  logic                 ras_fall, ras_rise, cas_fall, cas_rise, trg_rise, sc_rise;
  logic [ADDR_W-1:0]    row, col, tap;
  logic                 wr_en, load;
  logic [DQ_W-1:0]      rd_data;
  logic [COLS*DQ_W-1:0] row_bus;

  vram_edge #(.N(4), .IDLE(4'b1110)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({ras_ni, cas_ni, trg_ni, sc_i}),
    .prev_o (prv)
  );

  assign ras_fall = prv[3] & ~ras_ni;
  assign ras_rise = ~prv[3] & ras_ni;
  assign cas_fall = prv[2] & ~cas_ni;
  assign cas_rise = ~prv[2] & cas_ni;
  assign trg_rise = ~prv[1] & trg_ni;
  assign sc_rise  = ~prv[0] & sc_i;

  vram_ctrl #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_ni     (ras_ni),
    .ras_fall_i (ras_fall),
    .ras_rise_i (ras_rise),
    .cas_fall_i (cas_fall),
    .cas_rise_i (cas_rise),
    .trg_ni     (trg_ni),
    .trg_rise_i (trg_rise),
    .we_ni      (we_ni),
    .addr_i     (addr_i),
    .rd_data_i  (rd_data),
    .row_o      (row),
    .col_o      (col),
    .wr_en_o    (wr_en),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o),
    .load_o     (load),
    .tap_o      (tap)
  );

  vram_array #(.ROWS(ROWS), .COLS(COLS), .DQ_W(DQ_W), .ADDR_W(ADDR_W)) u_array (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .row_i     (row),
    .col_i     (col),
    .din_i     (dq_i),
    .rd_data_o (rd_data),
    .row_bus_o (row_bus)
  );

  vram_sam #(.COLS(COLS), .DQ_W(DQ_W), .PTR_W(ADDR_W)) u_sam (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .tap_i     (tap),
    .row_bus_i (row_bus),
    .sc_rise_i (sc_rise),
    .se_ni     (se_ni),
    .sdq_i     (sdq_i),
    .sdq_o     (sdq_o),
    .sdq_oe_o  (sdq_oe_o),
    .qsf_o     (qsf_o)
  );
endmodule

// File: tb/vram_xfer_port_bench.sv
`timescale 1ns/1ps
module vram_xfer_port_bench;
  localparam int ROWS = 4;
  localparam int COLS = 512;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, trg_n = 1'b1, we_n = 1'b1;
  logic [8:0] addr = '0;
  logic [3:0] dq_in = '0;
  logic [3:0] dq_out;
  logic       dq_oe;
  logic       sc = 1'b0, se_n = 1'b1;
  logic [3:0] sdq_in = '0;
  logic [3:0] sdq_out;
  logic       sdq_oe, qsf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int cur_row = 0;
  int bptr = 0;
  logic [3:0] exp_q[$];
  event sc_ev;

  always #2.5 clk = ~clk;

  vram_xfer_port u_vram_xfer_port (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .trg_ni(trg_n), .we_ni(we_n), .addr_i(addr), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe), .sc_i(sc), .se_ni(se_n),
    .sdq_i(sdq_in), .sdq_o(sdq_out), .sdq_oe_o(sdq_oe), .qsf_o(qsf)
  );

  function automatic logic [3:0] pat(int r, int c);
    return 4'((r * 7 + c * 3 + (c >> 5)) & 15);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected serial words as the design presents them
  initial begin
    forever begin
      @(sc_ev);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 R4 R6 empty scoreboard", 0, 1);
      end else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(sdq_oe === 1'b1, "R5 sdq_oe during stream", int'(sdq_oe), 1);
        chk(sdq_out === e, "R3 R4 R6 serial word", int'(sdq_out), int'(e));
      end
    end
  end

  task automatic write_row(int r);
    @(negedge clk); ras_n = 1'b0; addr = 9'(r);
    @(negedge clk);
    for (int c = 0; c < COLS; c++) begin
      addr = 9'(c); dq_in = pat(r, c); we_n = 1'b0; cas_n = 1'b0;
      @(negedge clk); cas_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
    end
    ras_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic read_chk(int r, int c);
    ras_n = 1'b0; addr = 9'(r);
    @(negedge clk); addr = 9'(c); cas_n = 1'b0;
    @(negedge clk);
    chk(dq_oe === 1'b1, "R1 dq_oe on read", int'(dq_oe), 1);
    chk(dq_out === pat(r, c), "R1 read data", int'(dq_out), int'(pat(r, c)));
    cas_n = 1'b1; ras_n = 1'b1;
    @(negedge clk);
    chk(dq_oe === 1'b0, "R1 dq_oe release", int'(dq_oe), 0);
  endtask

  task automatic xfer(int r, int tap, bit late);
    trg_n = 1'b0; ras_n = 1'b0; addr = 9'(r);
    @(negedge clk); addr = 9'(tap); cas_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    chk(dq_oe === 1'b0, "R2 dq hi-z in transfer", int'(dq_oe), 0);
    if (!late) begin
      trg_n = 1'b1;
      @(negedge clk); ras_n = 1'b1; cas_n = 1'b1;
      @(negedge clk);
    end else begin
      ras_n = 1'b1; cas_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(dq_oe === 1'b0, "R9 dq hi-z before late load", int'(dq_oe), 0);
      trg_n = 1'b1;
      @(negedge clk);
    end
    @(negedge clk);
    cur_row = r; bptr = tap;
    se_n = 1'b0;
    #0.1;
    chk(sdq_oe === 1'b0, "R5 no data before first SC", int'(sdq_oe), 0);
    chk(qsf === 1'(tap >> 8), "R8 qsf from tap", int'(qsf), (tap >> 8) & 1);
  endtask

  task automatic shift(int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(pat(cur_row, bptr));
      sc = 1'b1;
      @(negedge clk);
      ->sc_ev;
      bptr = (bptr + 1) % COLS;
      sc = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(dq_oe === 1'b0, "R11 dq_oe reset", int'(dq_oe), 0);
    chk(sdq_oe === 1'b0, "R11 sdq_oe reset", int'(sdq_oe), 0);
    chk(qsf === 1'b0, "R11 qsf reset", int'(qsf), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 input mode: SC toggling with SE low never drives SDQ
    se_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      sdq_in = 4'(i + 9); sc = 1'b1;
      @(negedge clk);
      chk(sdq_oe === 1'b0, "R10 input mode hi-z", int'(sdq_oe), 0);
      sc = 1'b0;
      @(negedge clk);
    end
    se_n = 1'b1;

    for (int r = 0; r < ROWS; r++) write_row(r);
    read_chk(1, 5);
    read_chk(2, 300);
    read_chk(3, 511);

    // normal transfer, tap in lower half
    xfer(1, 5, 1'b0);
    shift(20);
    chk(qsf === 1'b0, "R8 qsf lower half", int'(qsf), 0);

    // R7 serial enable high: hi-z and pointer held
    se_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      sc = 1'b1;
      @(negedge clk);
      chk(sdq_oe === 1'b0, "R7 hi-z while SE high", int'(sdq_oe), 0);
      sc = 1'b0;
      @(negedge clk);
    end
    se_n = 1'b0;
    shift(5);

    // R9 late load with tap near the top, then wrap (R6)
    xfer(2, 508, 1'b1);
    shift(4);
    chk(qsf === 1'b0, "R6 R8 qsf after wrap", int'(qsf), 0);
    shift(4);

    // R3 full lap from a mid-row tap
    xfer(3, 300, 1'b0);
    chk(qsf === 1'b1, "R8 qsf upper half", int'(qsf), 1);
    shift(COLS);
    chk(qsf === 1'b1, "R6 pointer back at tap", int'(qsf), 1);

    @(negedge clk);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule